// File: doc/BRIEF.md
# Triggered Sweep Accumulator for a Two-Channel Sampling ADC

This block drives an external 12-bit sampling converter that sits behind a four-input analog multiplexer, of which two inputs are used. A start command makes it raise a trigger towards an external signal generator. Once the generator reports back that its waveform has begun, the block issues one conversion after another. It alternates the multiplexer between the two channels and adds each result into an on-chip memory word whose index is the sample's position in the sweep.

A sweep fills the whole memory once, with channel A at even indices and channel B at odd ones. The block repeats the triggered sweep a fixed number of times, summing in place, so signals that repeat with the trigger add up coherently while uncorrelated noise averages out. When the last sweep has been added, a done flag comes up and the sums can be fetched through a synchronous read port. A clear command zeroes the memory beforehand.

Top module: `sweep_accum_top`

## Requirements
- R1: After reset, `done_o` and `trig_out_o` are low and `adc_conv_n_o` is high.
- R2: A `clear_i` pulse given while idle or done zeroes every memory word and drops `done_o`.
- R3: `start_i` raises `trig_out_o`. No conversion begins until `trig_in_i` is high. Between sweeps `trig_out_o` drops, and the next sweep re-arms only after `trig_in_i` has gone low, so each sweep has its own trigger handshake.
- R4: A conversion is requested by driving `adc_conv_n_o` low for exactly CONV_LOW clock cycles. Successive falling edges are at least CONV_PERIOD cycles apart.
- R5: On each rising edge of `adc_eoc_i`, the value on `adc_data_i` is added to the memory word at the current sweep index. The read-modify-write finishes before the next conversion is requested.
- R6: During each conversion, `mux_sel_o` equals CH_A_SEL (default 0) for even sweep indices and CH_B_SEL (default 1) for odd ones, and it stays stable while `adc_conv_n_o` is low.
- R7: A sweep consists of DEPTH conversions. After NUM_SWEEPS sweeps, `done_o` rises and stays high until the next start or clear; it is never high earlier.
- R8: ACC_W must be at least SAMPLE_W plus log2(NUM_SWEEPS), which is checked at elaboration. Full-scale samples (4095) therefore sum to NUM_SWEEPS*4095 without wrapping.
- R9: `start_i` and `clear_i` have no effect while a run is in progress.
- R10: `rd_data_o` presents the word at `rd_addr_i` one clock after the address is applied.
- R11: A start from the done state sums a further NUM_SWEEPS sweeps on top of the existing contents without clearing them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run of triggered sweeps |
| clear_i | input | 1 | Zero the accumulation memory |
| adc_conv_n_o | output | 1 | Conversion request to the ADC, falling edge starts |
| adc_eoc_i | input | 1 | End of conversion from the ADC, rising edge = data valid |
| adc_data_i | input | SAMPLE_W | Conversion result |
| mux_sel_o | output | SEL_W | Analog multiplexer select |
| trig_out_o | output | 1 | Arm request to the signal generator |
| trig_in_i | input | 1 | Generator reports waveform started |
| done_o | output | 1 | All sweeps accumulated |
| rd_addr_i | input | ADDR_W | Memory read address |
| rd_data_o | output | ACC_W | Memory read data |

## Verification
If the sweep index goes wrong, words are summed at the wrong addresses and the multiplexer select is out of phase, so read-back sums disagree with the expected values and the select seen at each conversion falling edge is wrong within the first two conversions. A faulty sweep or repetition counter shows up as a conversion count that differs from DEPTH times NUM_SWEEPS when `done_o` rises, or as fewer trigger handshakes. A broken read-modify-write gives sums that are off by a whole sweep at the end of the run. Pacing faults are visible at once as a short gap or a wrong low width on `adc_conv_n_o`.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CLEAR,
      ST_ARM,
      ST_SWEEP,
      ST_REARM,
      ST_DONE
   } seq_state_t;

endpackage

// File: rtl/adc_pacer.sv
// Conversion request generator, end-of-conversion synchroniser and result capture.
module adc_pacer #(
   parameter int SAMPLE_W    = 12,
   parameter int CONV_PERIOD = 100,
   parameter int CONV_LOW    = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go_i,
   input  logic                eoc_i,
   input  logic [SAMPLE_W-1:0] data_i,
   output logic                conv_n_o,
   output logic                ready_o,
   output logic                smp_vld_o,
   output logic [SAMPLE_W-1:0] smp_o
);

   localparam int PACE_W = $clog2(CONV_PERIOD + 1);
   localparam int LOW_W  = $clog2(CONV_LOW + 1);

   if (CONV_LOW < 1 || CONV_LOW >= CONV_PERIOD) begin : g_bad_timing
      $error("adc_pacer: CONV_LOW must lie in 1..CONV_PERIOD-1");
   end

   logic [PACE_W-1:0] pace_cnt;
   logic [LOW_W-1:0]  low_cnt;
   logic              eoc_q1, eoc_q2, eoc_q3;
   logic              eoc_rise;

   assign eoc_rise = eoc_q2 & ~eoc_q3;
   assign ready_o  = (pace_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pace_cnt <= '0;
         low_cnt  <= '0;
         conv_n_o <= 1'b1;
      end else begin
         if (go_i) begin
            pace_cnt <= PACE_W'(CONV_PERIOD - 1);
            low_cnt  <= LOW_W'(CONV_LOW - 1);
            conv_n_o <= 1'b0;
         end else begin
            if (pace_cnt != '0) pace_cnt <= pace_cnt - 1'b1;
            if (low_cnt != '0) low_cnt <= low_cnt - 1'b1;
            else               conv_n_o <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eoc_q1    <= 1'b0;
         eoc_q2    <= 1'b0;
         eoc_q3    <= 1'b0;
         smp_vld_o <= 1'b0;
         smp_o     <= '0;
      end else begin
         eoc_q1    <= eoc_i;
         eoc_q2    <= eoc_q1;
         eoc_q3    <= eoc_q2;
         smp_vld_o <= eoc_rise;
         if (eoc_rise) smp_o <= data_i;
      end
   end

   // R4: a new request only when the pacing window has elapsed
   assert_go_paced_R4: assert property (@(posedge clk) disable iff (!rst_n)
      go_i |-> (ready_o && conv_n_o));

   if (CONV_LOW >= 2) begin : g_width_chk
      // R4: the low pulse is never a single cycle when more is asked
      assert_conv_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(conv_n_o) |=> !conv_n_o);
   end

endmodule

// File: rtl/accum_mem.sv
// Accumulation memory: two-cycle read-modify-write, clear port, user read port.
module accum_mem #(
   parameter int ACC_W      = 16,
   parameter int SAMPLE_W   = 12,
   parameter int DEPTH      = 2048,
   parameter int ADDR_W     = 11,
   parameter int RD_LATENCY = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_i,
   input  logic [ADDR_W-1:0]   clr_addr_i,
   input  logic                acc_i,
   input  logic [ADDR_W-1:0]   acc_addr_i,
   input  logic [SAMPLE_W-1:0] acc_data_i,
   output logic                acc_done_o,
   input  logic [ADDR_W-1:0]   rd_addr_i,
   output logic [ACC_W-1:0]    rd_data_o
);

   localparam int PAD_W = ACC_W - SAMPLE_W;

   if (PAD_W < 1) begin : g_bad_width
      $error("accum_mem: ACC_W must exceed SAMPLE_W");
   end
   if (RD_LATENCY != 0 && RD_LATENCY != 1) begin : g_bad_lat
      $error("accum_mem: RD_LATENCY must be 0 or 1");
   end

   logic [ACC_W-1:0]    mem [DEPTH];
   logic                pend;
   logic [ADDR_W-1:0]   hold_addr;
   logic [SAMPLE_W-1:0] hold_data;
   logic [ACC_W-1:0]    old_word;
   logic [ACC_W-1:0]    new_word;

   assign new_word = old_word + {{PAD_W{1'b0}}, hold_data};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend       <= 1'b0;
         acc_done_o <= 1'b0;
      end else begin
         pend       <= acc_i;
         acc_done_o <= pend;
      end
   end

   always_ff @(posedge clk) begin
      if (acc_i) begin
         hold_addr <= acc_addr_i;
         hold_data <= acc_data_i;
         old_word  <= mem[acc_addr_i];
      end
      if (clr_i)     mem[clr_addr_i] <= '0;
      else if (pend) mem[hold_addr]  <= new_word;
   end

   if (RD_LATENCY == 1) begin : g_rd_reg
      always_ff @(posedge clk) rd_data_o <= mem[rd_addr_i];
   end else begin : g_rd_comb
      assign rd_data_o = mem[rd_addr_i];
   end

   // R5: a new sample never arrives while the previous one is being written back
   assert_rmw_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_i |-> !pend);

   // R2: clearing never overlaps accumulation traffic
   assert_clr_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |-> (!pend && !acc_i));

endmodule

// File: rtl/sweep_seq.sv
// Run sequencer: clear walk, trigger handshake, sweep index and repetition count.
module sweep_seq
   import sweep_pkg::*;
#(
   parameter int DEPTH      = 2048,
   parameter int ADDR_W     = 11,
   parameter int NUM_SWEEPS = 16,
   parameter int SEL_W      = 2,
   parameter int CH_A_SEL   = 0,
   parameter int CH_B_SEL   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              clear_i,
   input  logic              trig_in_i,
   input  logic              adc_ready_i,
   input  logic              smp_vld_i,
   input  logic              acc_done_i,
   output logic              go_o,
   output logic              acc_o,
   output logic [ADDR_W-1:0] idx_o,
   output logic              clr_o,
   output logic              trig_out_o,
   output logic [SEL_W-1:0]  mux_sel_o,
   output logic              done_o
);

   localparam int                SWP_W    = (NUM_SWEEPS > 1) ? $clog2(NUM_SWEEPS) : 1;
   localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);
   localparam logic [SWP_W-1:0]  LAST_SWP = SWP_W'(NUM_SWEEPS - 1);

   if (DEPTH < 2 || (DEPTH % 2) != 0 || ADDR_W != $clog2(DEPTH)) begin : g_bad_depth
      $error("sweep_seq: DEPTH must be even and ADDR_W its log2");
   end
   if (CH_A_SEL >= (1 << SEL_W) || CH_B_SEL >= (1 << SEL_W)) begin : g_bad_sel
      $error("sweep_seq: channel select does not fit SEL_W");
   end

   seq_state_t        state;
   logic [ADDR_W-1:0] idx;
   logic [SWP_W-1:0]  swp;
   logic              waiting;
   logic              trig_q1, trig_q2;

   assign go_o       = (state == ST_SWEEP) && adc_ready_i && !waiting;
   assign acc_o      = smp_vld_i && (state == ST_SWEEP);
   assign idx_o      = idx;
   assign clr_o      = (state == ST_CLEAR);
   assign trig_out_o = (state == ST_ARM) || (state == ST_SWEEP);
   assign done_o     = (state == ST_DONE);
   assign mux_sel_o  = idx[0] ? SEL_W'(CH_B_SEL) : SEL_W'(CH_A_SEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         idx     <= '0;
         swp     <= '0;
         waiting <= 1'b0;
         trig_q1 <= 1'b0;
         trig_q2 <= 1'b0;
      end else begin
         trig_q1 <= trig_in_i;
         trig_q2 <= trig_q1;
         if (go_o)            waiting <= 1'b1;
         else if (acc_done_i) waiting <= 1'b0;
         case (state)
            ST_IDLE, ST_DONE: begin
               if (clear_i) begin
                  state <= ST_CLEAR;
                  idx   <= '0;
               end else if (start_i) begin
                  state <= ST_ARM;
                  idx   <= '0;
                  swp   <= '0;
               end
            end
            ST_CLEAR: begin
               if (idx == LAST_IDX) begin
                  idx   <= '0;
                  state <= ST_IDLE;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_ARM: begin
               if (trig_q2) state <= ST_SWEEP;
            end
            ST_SWEEP: begin
               if (acc_done_i) begin
                  if (idx == LAST_IDX) begin
                     idx <= '0;
                     if (swp == LAST_SWP) begin
                        state <= ST_DONE;
                     end else begin
                        swp   <= swp + 1'b1;
                        state <= ST_REARM;
                     end
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            ST_REARM: begin
               if (!trig_q2) state <= ST_ARM;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R7: completion follows directly on a finished accumulation
   assert_done_after_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(acc_done_i));

   // R3: a sweep is entered only with the generator acknowledge present
   assert_sweep_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_ARM && state == ST_SWEEP) |-> $past(trig_q2));

endmodule

// File: rtl/sweep_accum_top.sv
module sweep_accum_top #(
   parameter int SAMPLE_W    = 12,
   parameter int ACC_W       = 16,
   parameter int DEPTH       = 2048,
   parameter int NUM_SWEEPS  = 16,
   parameter int CONV_PERIOD = 100,
   parameter int CONV_LOW    = 20,
   parameter int SEL_W       = 2,
   parameter int CH_A_SEL    = 0,
   parameter int CH_B_SEL    = 1,
   parameter int RD_LATENCY  = 1,
   parameter int ADDR_W      = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                clear_i,
   output logic                adc_conv_n_o,
   input  logic                adc_eoc_i,
   input  logic [SAMPLE_W-1:0] adc_data_i,
   output logic [SEL_W-1:0]    mux_sel_o,
   output logic                trig_out_o,
   input  logic                trig_in_i,
   output logic                done_o,
   input  logic [ADDR_W-1:0]   rd_addr_i,
   output logic [ACC_W-1:0]    rd_data_o
);

   localparam int GROWTH = (NUM_SWEEPS > 1) ? $clog2(NUM_SWEEPS) : 0;

   // R8: the sum of all sweeps must fit one memory word
   if (ACC_W < SAMPLE_W + GROWTH) begin : g_bad_acc
      $error("sweep_accum_top: ACC_W too narrow for NUM_SWEEPS sums");
   end
   if (NUM_SWEEPS < 1) begin : g_bad_swp
      $error("sweep_accum_top: NUM_SWEEPS must be positive");
   end

   logic                go, ready, smp_vld, acc, acc_done, clr;
   logic [SAMPLE_W-1:0] smp;
   logic [ADDR_W-1:0]   idx;

   adc_pacer #(
      .SAMPLE_W   (SAMPLE_W),
      .CONV_PERIOD(CONV_PERIOD),
      .CONV_LOW   (CONV_LOW)
   ) u_pacer (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_i     (go),
      .eoc_i    (adc_eoc_i),
      .data_i   (adc_data_i),
      .conv_n_o (adc_conv_n_o),
      .ready_o  (ready),
      .smp_vld_o(smp_vld),
      .smp_o    (smp)
   );

   sweep_seq #(
      .DEPTH     (DEPTH),
      .ADDR_W    (ADDR_W),
      .NUM_SWEEPS(NUM_SWEEPS),
      .SEL_W     (SEL_W),
      .CH_A_SEL  (CH_A_SEL),
      .CH_B_SEL  (CH_B_SEL)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .clear_i    (clear_i),
      .trig_in_i  (trig_in_i),
      .adc_ready_i(ready),
      .smp_vld_i  (smp_vld),
      .acc_done_i (acc_done),
      .go_o       (go),
      .acc_o      (acc),
      .idx_o      (idx),
      .clr_o      (clr),
      .trig_out_o (trig_out_o),
      .mux_sel_o  (mux_sel_o),
      .done_o     (done_o)
   );

   accum_mem #(
      .ACC_W     (ACC_W),
      .SAMPLE_W  (SAMPLE_W),
      .DEPTH     (DEPTH),
      .ADDR_W    (ADDR_W),
      .RD_LATENCY(RD_LATENCY)
   ) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr),
      .clr_addr_i(idx),
      .acc_i     (acc),
      .acc_addr_i(idx),
      .acc_data_i(smp),
      .acc_done_o(acc_done),
      .rd_addr_i (rd_addr_i),
      .rd_data_o (rd_data_o)
   );

   // R3: conversions are only requested while the trigger is raised
   assert_conv_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_conv_n_o) |-> trig_out_o);

   // R6: the channel select holds for the whole conversion pulse
   assert_sel_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_conv_n_o |-> $stable(mux_sel_o));

   // R7: no conversion activity once the run is complete
   assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> adc_conv_n_o);

endmodule

// File: tb/tb_sweep_accum_top.sv
module tb_sweep_accum_top;

   localparam int CLK_PERIOD  = 10;
   localparam int SAMPLE_W    = 12;
   localparam int ACC_W       = 16;
   localparam int DEPTH       = 16;
   localparam int NUM_SWEEPS  = 4;
   localparam int CONV_PERIOD = 8;
   localparam int CONV_LOW    = 2;
   localparam int ADDR_W      = $clog2(DEPTH);
   localparam int TRIG_DLY    = 4;
   localparam int TOTAL       = DEPTH * NUM_SWEEPS;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start_i = 1'b0;
   logic                clear_i = 1'b0;
   logic                adc_conv_n_o;
   logic                adc_eoc_i = 1'b0;
   logic [SAMPLE_W-1:0] adc_data_i = '0;
   logic [1:0]          mux_sel_o;
   logic                trig_out_o;
   logic                trig_in_i = 1'b0;
   logic                done_o;
   logic [ADDR_W-1:0]   rd_addr_i = '0;
   logic [ACC_W-1:0]    rd_data_o;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  finished = 0;
   int  pattern  = 0;
   bit  hold_trig = 0;
   int  conv_total = 0;
   int  sel_errs = 0;
   int  arms = 0;
   int  min_gap = 1000000;
   int  width_errs = 0;
   int  done_at = -1;

   sweep_accum_top #(
      .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .DEPTH(DEPTH), .NUM_SWEEPS(NUM_SWEEPS),
      .CONV_PERIOD(CONV_PERIOD), .CONV_LOW(CONV_LOW)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .clear_i(clear_i),
      .adc_conv_n_o(adc_conv_n_o), .adc_eoc_i(adc_eoc_i), .adc_data_i(adc_data_i),
      .mux_sel_o(mux_sel_o), .trig_out_o(trig_out_o), .trig_in_i(trig_in_i),
      .done_o(done_o), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic int adc_value(int k, int sel);
      if (pattern == 1) return 4095;
      return (sel * 1024 + k * 37 + 5) % 4096;
   endfunction

   function automatic int expect_word(int k, int runs);
      return (runs * NUM_SWEEPS * adc_value(k, k % 2)) % 65536;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // ADC model: falling conv edge starts, result then EOC rise a few cycles later
   initial begin
      bit prev = 1'b1;
      forever begin
         @(negedge clk);
         if (prev && !adc_conv_n_o) begin
            int k;
            int s;
            k = conv_total % DEPTH;
            s = int'(mux_sel_o);
            if (s != k % 2) sel_errs++;
            conv_total++;
            @(negedge clk);
            @(negedge clk);
            adc_data_i = SAMPLE_W'(adc_value(k, s));
            @(negedge clk);
            adc_eoc_i = 1'b1;
            @(negedge clk);
            @(negedge clk);
            adc_eoc_i = 1'b0;
         end
         prev = adc_conv_n_o;
      end
   end

   // Signal generator model: acknowledges the trigger after a short delay
   initial begin
      int wait_cnt = 0;
      forever begin
         @(negedge clk);
         if (!trig_out_o) begin
            trig_in_i = 1'b0;
            wait_cnt  = 0;
         end else if (!trig_in_i && !hold_trig) begin
            if (wait_cnt >= TRIG_DLY) trig_in_i = 1'b1;
            else wait_cnt++;
         end
      end
   end

   // Pin monitor: pacing, pulse width, trigger arms, completion point
   initial begin
      int  cyc = 0;
      int  last_fall = -1000000;
      int  low_len = 0;
      bit  conv_prev = 1'b1;
      bit  trig_prev = 1'b0;
      bit  done_prev = 1'b0;
      forever begin
         @(negedge clk);
         cyc++;
         if (conv_prev && !adc_conv_n_o) begin
            if (cyc - last_fall < min_gap) min_gap = cyc - last_fall;
            last_fall = cyc;
            low_len = 0;
         end
         if (!adc_conv_n_o) low_len++;
         if (!conv_prev && adc_conv_n_o && low_len != CONV_LOW) width_errs++;
         if (!trig_prev && trig_out_o) arms++;
         if (!done_prev && done_o) done_at = conv_total;
         conv_prev = adc_conv_n_o;
         trig_prev = trig_out_o;
         done_prev = done_o;
      end
   end

   task automatic pulse_start();
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
   endtask

   task automatic pulse_clear();
      @(negedge clk) clear_i = 1'b1;
      @(negedge clk) clear_i = 1'b0;
      repeat (DEPTH + 2) @(negedge clk);
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done_o && n < 20000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic reset_stats();
      conv_total = 0; sel_errs = 0; arms = 0; min_gap = 1000000;
      width_errs = 0; done_at = -1;
   endtask

   task automatic read_word(int a, output int v);
      @(negedge clk) rd_addr_i = ADDR_W'(a);
      @(negedge clk) v = int'(rd_data_o);
   endtask

   task automatic check_memory(int runs, string req);
      int bad = 0;
      int first_act = 0;
      int first_exp = 0;
      for (int a = 0; a < DEPTH; a++) begin
         int v;
         read_word(a, v);
         if (v != expect_word(a, runs) && bad == 0) begin
            first_act = v;
            first_exp = expect_word(a, runs);
         end
         if (v != expect_word(a, runs)) bad++;
      end
      check(bad == 0, req, first_act, first_exp);
   endtask

   task automatic t_reset();
      check(done_o == 1'b0, "R1 done", int'(done_o), 0);
      check(trig_out_o == 1'b0, "R1 trig_out", int'(trig_out_o), 0);
      check(adc_conv_n_o == 1'b1, "R1 conv_n", int'(adc_conv_n_o), 1);
   endtask

   task automatic t_clear();
      int bad = 0;
      pulse_clear();
      for (int a = 0; a < DEPTH; a++) begin
         int v;
         read_word(a, v);
         if (v != 0) bad++;
      end
      check(bad == 0, "R2 clear zeroes words", bad, 0);
      check(done_o == 1'b0, "R2 done low after clear", int'(done_o), 0);
   endtask

   task automatic t_basic_run();
      pattern = 0;
      reset_stats();
      pulse_start();
      wait_done();
      check(done_o == 1'b1, "R7 done raised", int'(done_o), 1);
      check(done_at == TOTAL, "R7 conversions at done", done_at, TOTAL);
      check(arms == NUM_SWEEPS, "R3 trigger per sweep", arms, NUM_SWEEPS);
      check(sel_errs == 0, "R6 interleaved select", sel_errs, 0);
      check(min_gap >= CONV_PERIOD, "R4 conversion spacing", min_gap, CONV_PERIOD);
      check(width_errs == 0, "R4 low pulse width", width_errs, 0);
      check_memory(1, "R5 R10 summed words");
      repeat (30) @(negedge clk);
      check(done_o == 1'b1, "R7 done holds", int'(done_o), 1);
   endtask

   task automatic t_accumulate_more();
      reset_stats();
      pulse_start();
      @(negedge clk);
      check(done_o == 1'b0, "R11 done drops on start", int'(done_o), 0);
      wait_done();
      check(conv_total == TOTAL, "R11 second run length", conv_total, TOTAL);
      check_memory(2, "R11 sums stack on old contents");
   endtask

   task automatic t_ignore_busy();
      int n = 0;
      pulse_clear();
      reset_stats();
      pulse_start();
      while (conv_total < 20 && n < 5000) begin
         @(negedge clk);
         n++;
      end
      @(negedge clk) begin start_i = 1'b1; clear_i = 1'b1; end
      @(negedge clk) begin start_i = 1'b0; clear_i = 1'b0; end
      wait_done();
      check(done_at == TOTAL, "R9 run length unchanged", done_at, TOTAL);
      check_memory(1, "R9 words unaffected by busy commands");
   endtask

   task automatic t_trigger_hold();
      pulse_clear();
      reset_stats();
      hold_trig = 1'b1;
      pulse_start();
      repeat (60) @(negedge clk);
      check(conv_total == 0, "R3 no conversion before ack", conv_total, 0);
      check(trig_out_o == 1'b1, "R3 trigger raised", int'(trig_out_o), 1);
      hold_trig = 1'b0;
      wait_done();
      check(done_at == TOTAL, "R3 run after late ack", done_at, TOTAL);
   endtask

   task automatic t_full_scale();
      pulse_clear();
      pattern = 1;
      reset_stats();
      pulse_start();
      wait_done();
      check_memory(1, "R8 full-scale sum no wrap");
      pattern = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_clear();
      t_basic_run();
      t_accumulate_more();
      t_ignore_busy();
      t_trigger_hold();
      t_full_scale();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule